// File: doc/BRIEF.md
# Four-Context Barrel Thread Scheduler

This block lets a single shared stack-machine datapath serve four hardware contexts. A slot counter names one active context per clock, in fixed order 0, 1, 2, 3, 0 and so on. For the active context, the block shows that context's program counter and the tops of its data and return stacks. It takes back a next program counter and stack operations from the shared ALU, and applies them only to the context whose slot it is. Each context therefore runs at exactly one quarter of the clock rate. Memory and I/O accesses from the contexts interleave in the same fixed order, with no jitter.

A small I/O-mapped dispatch peripheral sits beside the banks. Context 0 is the interactive context and is never controlled by the peripheral. Context 0 can give each background context (1 to 3) an execution address, and it can clear that address by writing zero. A background context polls its own address through a self-read location, and it runs the routine there while the value is nonzero. Context 0 can also restart any single background context: the restart zeroes that context's program counter and empties both of its stacks, and leaves everything else as it was.

Top module: `barrel_sched`

## Requirements
- R1: After reset `ctx_o` is 0, and it then advances by one every clock, wrapping from 3 to 0.
- R2: `pc_o` shows the program counter of the active context. When `pc_we_i` is high at a clock edge, only the active context's counter takes `pc_next_i`.
- R3: Each context has its own data stack. The operations are push (`ds_push_i`), pop (`ds_pop_i`), and replace-top when both are high. `ds_tos_o` and `ds_depth_o` report the active context's top value and entry count, and the top value reads 0 when the stack is empty.
- R4: Each context has its own return stack with the same operations on the `rs_*` ports. It is fully separate from the data stack.
- R5: An I/O write while context 0 is active, to address k with k from 1 to 3, loads bits [11:0] of `io_wdata_i` into context k's execution address. Writes issued by contexts 1 to 3 have no effect, and so do writes to address 0.
- R6: A read at address 0 returns the active context's own execution address, and context 0 always reads 0 there. A read at address k (1 to 3) returns context k's execution address, zero-extended.
- R7: Writing 0 to a context's execution address clears it, and the next self-read of that context returns 0.
- R8: A context-0 write to address 15 restarts context k for each bit k (1 to 3) that is set in the written data. The restarted context gets program counter 0 and empty stacks. Bit 0 is ignored, and the other contexts and all execution addresses are kept.
- R9: Global reset sets every execution address and program counter to 0 and empties every stack.
- R10: A push onto a full stack (8 entries) and a pop from an empty stack are ignored. The reported depth never exceeds 8.
- R11: Reads at address 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| ctx_o | output | 2 | Context owning the current slot |
| pc_o | output | 12 | Program counter of the active context |
| pc_we_i | input | 1 | Write `pc_next_i` into the active context's counter |
| pc_next_i | input | 12 | Next program counter from the datapath |
| ds_push_i | input | 1 | Data stack push |
| ds_pop_i | input | 1 | Data stack pop |
| ds_din_i | input | 16 | Data stack write value |
| ds_tos_o | output | 16 | Active context's data stack top |
| ds_depth_o | output | 4 | Active context's data stack entry count |
| rs_push_i | input | 1 | Return stack push |
| rs_pop_i | input | 1 | Return stack pop |
| rs_din_i | input | 16 | Return stack write value |
| rs_tos_o | output | 16 | Active context's return stack top |
| rs_depth_o | output | 4 | Active context's return stack entry count |
| io_we_i | input | 1 | Peripheral write strobe from the active context |
| io_addr_i | input | 4 | Peripheral address |
| io_wdata_i | input | 16 | Peripheral write data |
| io_rdata_o | output | 16 | Peripheral read data, combinational |

## Verification
Outputs for the active slot are combinational from the slot counter and the banks. The bench therefore samples them on the falling edge of the slot in which they are wanted. An operation driven in context k's slot takes effect at the next rising edge. Its result can only be seen when k's slot comes round again, four cycles later, so every check waits for that slot. Peripheral writes from context 0 and restart pulses act at that same edge, and they are read back in the slot of the context they target.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
   typedef enum logic [1:0] {
      STK_HOLD = 2'b00,
      STK_PUSH = 2'b01,
      STK_POP  = 2'b10,
      STK_SWAP = 2'b11
   } stk_op_e;

   function automatic stk_op_e stk_decode(input logic push, input logic pop);
      return stk_op_e'({pop, push});
   endfunction
endpackage

// File: rtl/barrel_slot_ring.sv
module barrel_slot_ring #(
   parameter int NCTX = 4,
   localparam int CW = $clog2(NCTX)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] ctx_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctx_o <= '0;
      else        ctx_o <= ctx_o + 1'b1;
   end
endmodule

// File: rtl/barrel_stack_bank.sv
module barrel_stack_bank
   import barrel_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 8,
   parameter int NCTX  = 4,
   localparam int CW = $clog2(NCTX),
   localparam int PW = $clog2(DEPTH),
   localparam int DW = PW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   ctx_i,
   input  logic            push_i,
   input  logic            pop_i,
   input  logic [W-1:0]    din_i,
   input  logic [NCTX-1:0] clr_i,
   output logic [W-1:0]    tos_o,
   output logic [DW-1:0]   depth_o
);
   if (DEPTH < 2 || DEPTH != 2**PW) begin : g_bad_depth
      $error("stack depth must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [NCTX][DEPTH];
   logic [DW-1:0] sp  [NCTX];
   logic [DW-1:0] cur;
   logic          full, empty;
   stk_op_e       op;

   always_comb begin
      op      = stk_decode(push_i, pop_i);
      cur     = sp[ctx_i];
      full    = (cur == DW'(DEPTH));
      empty   = (cur == '0);
      depth_o = cur;
      tos_o   = empty ? '0 : mem[ctx_i][PW'(cur - 1'b1)];
   end

   for (genvar g = 0; g < NCTX; g++) begin : g_sp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   sp[g] <= '0;
         else if (clr_i[g])            sp[g] <= '0;
         else if (ctx_i == CW'(g)) begin
            if (op == STK_PUSH && !full)      sp[g] <= sp[g] + 1'b1;
            else if (op == STK_POP && !empty) sp[g] <= sp[g] - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (op == STK_PUSH && !full)       mem[ctx_i][PW'(cur)]        <= din_i;
      else if (op == STK_SWAP && !empty) mem[ctx_i][PW'(cur - 1'b1)] <= din_i;
   end
endmodule

// File: rtl/barrel_dispatch.sv
module barrel_dispatch #(
   parameter int NCTX  = 4,
   parameter int W     = 16,
   parameter int PC_W  = 12,
   parameter int IO_AW = 4,
   localparam int CW = $clog2(NCTX),
   localparam int RST_ADDR = 2**IO_AW - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    ctx_i,
   input  logic             we_i,
   input  logic [IO_AW-1:0] addr_i,
   input  logic [W-1:0]     wdata_i,
   output logic [W-1:0]     rdata_o,
   output logic [NCTX-1:0]  ctx_rst_o,
   output logic [NCTX*PC_W-1:0] xa_flat_o
);
   if (NCTX >= RST_ADDR || NCTX > W || PC_W > W) begin : g_bad_map
      $error("dispatch map does not fit the address or data width");
   end

   logic [PC_W-1:0] xa [NCTX];
   logic            owner_wr;
   logic            unused_hi;

   assign owner_wr  = we_i && (ctx_i == '0);
   assign unused_hi = ^wdata_i;
   assign xa[0]     = '0;
   assign ctx_rst_o[0] = 1'b0;
   assign xa_flat_o[PC_W-1:0] = xa[0];

   for (genvar g = 1; g < NCTX; g++) begin : g_xa
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  xa[g] <= '0;
         else if (owner_wr && addr_i == IO_AW'(g))    xa[g] <= wdata_i[PC_W-1:0];
      end
      assign ctx_rst_o[g] = owner_wr && (addr_i == IO_AW'(RST_ADDR)) && wdata_i[g];
      assign xa_flat_o[g*PC_W +: PC_W] = xa[g];
   end

   always_comb begin
      if (addr_i == '0)                  rdata_o = W'(xa[ctx_i]);
      else if (addr_i < IO_AW'(NCTX))    rdata_o = W'(xa[addr_i[CW-1:0]]);
      else                               rdata_o = '0;
   end
endmodule

// File: rtl/barrel_sched.sv
module barrel_sched #(
   parameter int NCTX  = 4,
   parameter int W     = 16,
   parameter int PC_W  = 12,
   parameter int DEPTH = 8,
   parameter int IO_AW = 4,
   localparam int CW = $clog2(NCTX),
   localparam int DW = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CW-1:0]    ctx_o,
   output logic [PC_W-1:0]  pc_o,
   input  logic             pc_we_i,
   input  logic [PC_W-1:0]  pc_next_i,
   input  logic             ds_push_i,
   input  logic             ds_pop_i,
   input  logic [W-1:0]     ds_din_i,
   output logic [W-1:0]     ds_tos_o,
   output logic [DW-1:0]    ds_depth_o,
   input  logic             rs_push_i,
   input  logic             rs_pop_i,
   input  logic [W-1:0]     rs_din_i,
   output logic [W-1:0]     rs_tos_o,
   output logic [DW-1:0]    rs_depth_o,
   input  logic             io_we_i,
   input  logic [IO_AW-1:0] io_addr_i,
   input  logic [W-1:0]     io_wdata_i,
   output logic [W-1:0]     io_rdata_o
);
   if (NCTX < 2 || NCTX != 2**CW) begin : g_bad_nctx
      $error("context count must be a power of two of at least 2");
   end

   logic [NCTX-1:0]      ctx_rst;
   logic [NCTX*PC_W-1:0] xa_flat;
   logic [PC_W-1:0]      pc_q [NCTX];

   barrel_slot_ring #(.NCTX(NCTX)) u_ring (
      .clk(clk), .rst_n(rst_n), .ctx_o(ctx_o)
   );

   for (genvar g = 0; g < NCTX; g++) begin : g_pc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               pc_q[g] <= '0;
         else if (ctx_rst[g])                      pc_q[g] <= '0;
         else if (pc_we_i && ctx_o == CW'(g))      pc_q[g] <= pc_next_i;
      end
   end
   assign pc_o = pc_q[ctx_o];

   barrel_stack_bank #(.W(W), .DEPTH(DEPTH), .NCTX(NCTX)) u_dstk (
      .clk(clk), .rst_n(rst_n), .ctx_i(ctx_o),
      .push_i(ds_push_i), .pop_i(ds_pop_i), .din_i(ds_din_i),
      .clr_i(ctx_rst), .tos_o(ds_tos_o), .depth_o(ds_depth_o)
   );

   barrel_stack_bank #(.W(W), .DEPTH(DEPTH), .NCTX(NCTX)) u_rstk (
      .clk(clk), .rst_n(rst_n), .ctx_i(ctx_o),
      .push_i(rs_push_i), .pop_i(rs_pop_i), .din_i(rs_din_i),
      .clr_i(ctx_rst), .tos_o(rs_tos_o), .depth_o(rs_depth_o)
   );

   barrel_dispatch #(.NCTX(NCTX), .W(W), .PC_W(PC_W), .IO_AW(IO_AW)) u_disp (
      .clk(clk), .rst_n(rst_n), .ctx_i(ctx_o),
      .we_i(io_we_i), .addr_i(io_addr_i), .wdata_i(io_wdata_i),
      .rdata_o(io_rdata_o), .ctx_rst_o(ctx_rst), .xa_flat_o(xa_flat)
   );
endmodule

// File: rtl/barrel_sched_chk.sv
module barrel_sched_chk #(
   parameter int NCTX  = 4,
   parameter int W     = 16,
   parameter int PC_W  = 12,
   parameter int DEPTH = 8,
   parameter int IO_AW = 4,
   localparam int CW = $clog2(NCTX),
   localparam int DW = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CW-1:0]    ctx_o,
   input logic             io_we_i,
   input logic [IO_AW-1:0] io_addr_i,
   input logic [W-1:0]     io_rdata_o,
   input logic [DW-1:0]    ds_depth_o,
   input logic [DW-1:0]    rs_depth_o,
   input logic [NCTX*PC_W-1:0] xa_flat
);
   AST_SLOT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ctx_o == CW'($past(ctx_o) + 1'b1)); // R1

   AST_XA_ONLY_CTX0_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_we_i && ctx_o == '0) |=> $stable(xa_flat)); // R5

   AST_CTX0_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_o == '0 && io_addr_i == '0) |-> io_rdata_o == '0); // R6

   AST_STACK_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ds_depth_o <= DW'(DEPTH) && rs_depth_o <= DW'(DEPTH)); // R10

   AST_RST_REG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      io_addr_i == '1 |-> io_rdata_o == '0); // R11
endmodule

bind barrel_sched barrel_sched_chk #(
   .NCTX(NCTX), .W(W), .PC_W(PC_W), .DEPTH(DEPTH), .IO_AW(IO_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ctx_o(ctx_o), .io_we_i(io_we_i),
   .io_addr_i(io_addr_i), .io_rdata_o(io_rdata_o),
   .ds_depth_o(ds_depth_o), .rs_depth_o(rs_depth_o), .xa_flat(xa_flat)
);

// File: tb/test_barrel_sched.sv
module test_barrel_sched;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ctx_o;
   logic [11:0] pc_o;
   logic        pc_we_i = 1'b0;
   logic [11:0] pc_next_i = '0;
   logic        ds_push_i = 1'b0, ds_pop_i = 1'b0;
   logic [15:0] ds_din_i = '0, ds_tos_o;
   logic [3:0]  ds_depth_o, rs_depth_o;
   logic        rs_push_i = 1'b0, rs_pop_i = 1'b0;
   logic [15:0] rs_din_i = '0, rs_tos_o;
   logic        io_we_i = 1'b0;
   logic [3:0]  io_addr_i = '0;
   logic [15:0] io_wdata_i = '0, io_rdata_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   barrel_sched i_barrel_sched (
      .clk(clk), .rst_n(rst_n), .ctx_o(ctx_o), .pc_o(pc_o),
      .pc_we_i(pc_we_i), .pc_next_i(pc_next_i),
      .ds_push_i(ds_push_i), .ds_pop_i(ds_pop_i), .ds_din_i(ds_din_i),
      .ds_tos_o(ds_tos_o), .ds_depth_o(ds_depth_o),
      .rs_push_i(rs_push_i), .rs_pop_i(rs_pop_i), .rs_din_i(rs_din_i),
      .rs_tos_o(rs_tos_o), .rs_depth_o(rs_depth_o),
      .io_we_i(io_we_i), .io_addr_i(io_addr_i), .io_wdata_i(io_wdata_i),
      .io_rdata_o(io_rdata_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // wait for a falling edge inside the slot of context k
   task automatic slot(input int k);
      @(negedge clk);
      while (ctx_o != 2'(k)) @(negedge clk);
   endtask

   task automatic io_wr(input int k, input logic [3:0] a, input logic [15:0] d);
      slot(k);
      io_we_i = 1'b1; io_addr_i = a; io_wdata_i = d;
      @(negedge clk);
      io_we_i = 1'b0; io_addr_i = '0; io_wdata_i = '0;
   endtask

   task automatic io_rd(input int k, input logic [3:0] a, input logic [15:0] exp, input string tag);
      slot(k);
      io_addr_i = a;
      #1 chk(tag, io_rdata_o, exp);
      io_addr_i = '0;
   endtask

   task automatic ds_op(input int k, input bit pu, input bit po, input logic [15:0] d);
      slot(k);
      ds_push_i = pu; ds_pop_i = po; ds_din_i = d;
      @(negedge clk);
      ds_push_i = 1'b0; ds_pop_i = 1'b0; ds_din_i = '0;
   endtask

   task automatic set_pc(input int k, input logic [11:0] v);
      slot(k);
      pc_we_i = 1'b1; pc_next_i = v;
      @(negedge clk);
      pc_we_i = 1'b0; pc_next_i = '0;
   endtask

   task automatic t_reset;
      chk("R1 ctx after reset", ctx_o, 0);
      chk("R9 pc after reset", pc_o, 0);
      chk("R9 ds depth after reset", ds_depth_o, 0);
      chk("R3 empty tos reads 0", ds_tos_o, 0);
      for (int k = 1; k < 4; k++) io_rd(0, 4'(k), 16'h0, "R9 xa after reset");
   endtask

   task automatic t_rotate;
      slot(0);
      for (int i = 0; i < 9; i++) begin
         chk("R1 rotation", ctx_o, 32'(i % 4));
         @(negedge clk);
      end
   endtask

   task automatic t_pc;
      for (int k = 0; k < 4; k++) set_pc(k, 12'h100 + 12'(k));
      for (int k = 0; k < 4; k++) begin
         slot(k);
         chk("R2 per-context pc", pc_o, 32'h100 + 32'(k));
      end
   endtask

   task automatic t_dstack;
      ds_op(1, 1, 0, 16'h0011);
      ds_op(2, 1, 0, 16'h0033);
      ds_op(1, 1, 0, 16'h0022);
      slot(1); chk("R3 ctx1 tos", ds_tos_o, 16'h0022); chk("R3 ctx1 depth", ds_depth_o, 2);
      slot(2); chk("R3 ctx2 tos", ds_tos_o, 16'h0033); chk("R3 ctx2 depth", ds_depth_o, 1);
      ds_op(1, 0, 1, 16'h0);
      ds_op(2, 1, 1, 16'h0044);
      slot(1); chk("R3 ctx1 tos after pop", ds_tos_o, 16'h0011);
      slot(2); chk("R3 ctx2 replace tos", ds_tos_o, 16'h0044); chk("R3 ctx2 replace depth", ds_depth_o, 1);
   endtask

   task automatic t_rstack;
      slot(3);
      rs_push_i = 1'b1; rs_din_i = 16'h0055;
      @(negedge clk);
      rs_push_i = 1'b0; rs_din_i = '0;
      slot(3);
      chk("R4 rs tos", rs_tos_o, 16'h0055);
      chk("R4 rs depth", rs_depth_o, 1);
      chk("R4 ds untouched", ds_depth_o, 0);
   endtask

   task automatic t_bounds;
      for (int i = 0; i < 9; i++) ds_op(0, 1, 0, 16'h00A0 + 16'(i));
      slot(0);
      chk("R10 full depth", ds_depth_o, 8);
      chk("R10 push on full ignored", ds_tos_o, 16'h00A7);
      for (int i = 0; i < 9; i++) ds_op(0, 0, 1, 16'h0);
      slot(0);
      chk("R10 pop on empty ignored", ds_depth_o, 0);
      chk("R10 empty tos", ds_tos_o, 0);
   endtask

   task automatic t_dispatch;
      io_wr(0, 4'd1, 16'h1234);
      io_wr(2, 4'd1, 16'h0DEA);
      io_wr(0, 4'd0, 16'h0777);
      io_rd(1, 4'd0, 16'h0234, "R5 ctx1 self read");
      io_rd(2, 4'd1, 16'h0234, "R5 write from ctx2 ignored");
      io_rd(0, 4'd0, 16'h0000, "R6 ctx0 self read");
      io_rd(2, 4'd0, 16'h0000, "R5 addr0 write ignored");
      io_rd(3, 4'd15, 16'h0000, "R11 reset reg reads 0");
      io_wr(0, 4'd1, 16'h0000);
      io_rd(1, 4'd0, 16'h0000, "R7 cleared");
   endtask

   task automatic t_ctx_reset;
      io_wr(0, 4'd2, 16'h02AB);
      ds_op(2, 1, 0, 16'h0077);
      io_wr(0, 4'd15, 16'h0005);
      slot(2);
      chk("R8 restarted pc", pc_o, 0);
      chk("R8 restarted ds", ds_depth_o, 0);
      slot(0); chk("R8 ctx0 pc kept", pc_o, 12'h100);
      slot(1); chk("R8 ctx1 pc kept", pc_o, 12'h101);
      chk("R8 ctx1 ds kept", ds_depth_o, 1);
      slot(3); chk("R8 ctx3 pc kept", pc_o, 12'h103);
      chk("R8 ctx3 rs kept", rs_depth_o, 1);
      io_rd(2, 4'd0, 16'h02AB, "R8 xa kept");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset;
      t_rotate;
      t_pc;
      t_dstack;
      t_rstack;
      t_bounds;
      t_dispatch;
      t_ctx_reset;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule